// File: doc/BRIEF.md
# Wired-AND Bus Arbitration Transmitter

This block is the transmit side of a node on a shared bus where a driven 0 (dominant) overrides a released 1 (recessive). When the bus has been quiet long enough, a start request loads an 11-bit identifier and a request-type bit. On the next bit strobe the block drives a dominant start bit. It then shifts the 12-bit arbitrated field out, most significant identifier bit first, one bit per strobe. At every strobe it reads the bus back. No node is in charge. Every sender applies the same rule: a sender that releases the line but reads it low has lost. It stops driving in that same bit period and listens to the rest of the field.

Bit stuffing applies to both directions. After five equal bus bits in a row, the opposite bit is sent and then discarded on receive. This keeps the stuff positions of every competing node identical for as long as their fields agree. When the field ends, the block reports the outcome as a won or lost pulse. A lost pulse carries the position of the losing bit. The block also exposes the field that actually appeared on the bus.

Top module: `can_arb_tx`

## Requirements
- R1: After reset, `tx_o` is 1 and `won_o`, `lost_o`, `rx_valid_o` are 0. A start request is accepted only once the block has sampled the bus recessive (1) at 11 consecutive strobes.
- R2: The strobe after an accepted start begins the frame, and each later strobe begins the next bit. Bus bits are a dominant start bit (0), then `id_i` from bit 10 down to bit 0, then `rtr_i`. The bus is sampled at the strobe that ends each bit.
- R3: After five consecutive equal bus bits (the start bit included), one bit of the opposite value is inserted. It starts a new run of length one and is not part of the field. No bit is inserted after the last field bit.
- R4: If the block drives 1 and samples 0 at a strobe, `lost_o` pulses in the next cycle. `lost_idx_o` then gives the field position: 0 is `id_i[10]`, 10 is `id_i[0]`, 11 is the request-type bit. From that cycle `tx_o` stays 1 until the frame ends.
- R5: If all 12 field bits are sampled without a mismatch, `won_o` pulses once, in the cycle after the last field bit. An opponent with an equal field does not cause a loss.
- R6: `rx_valid_o` pulses once, in the cycle after the twelfth field bit is sampled. At that point `rx_id_o` and `rx_rtr_o` hold the field as it appeared on the bus with stuff bits removed, whether the block won or lost.
- R7: A start request is ignored while a frame is in progress. It is also ignored after a frame ends until 11 further recessive bus bits have been sampled. A dominant sample restarts that count.
- R8: When two nodes contend, the one whose 12-bit {identifier, request-type} value is lower wins. The bus carries that value uncorrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick_i | input | 1 | One-cycle strobe marking a bit boundary |
| rx_i | input | 1 | Bus level read back (0 dominant) |
| start_i | input | 1 | Request to arbitrate with `id_i`/`rtr_i` |
| id_i | input | 11 | Identifier to send |
| rtr_i | input | 1 | Request-type bit, arbitrated after the identifier |
| tx_o | output | 1 | Bus drive (0 dominant, 1 released) |
| won_o | output | 1 | Pulse: whole field sent without mismatch |
| lost_o | output | 1 | Pulse: arbitration lost |
| lost_idx_o | output | 4 | Field position of the losing bit |
| rx_valid_o | output | 1 | Pulse: received field complete |
| rx_id_o | output | 11 | Identifier seen on the bus |
| rx_rtr_o | output | 1 | Request-type bit seen on the bus |

## Verification
Some rules are checked on every cycle by properties. A loss pulse must follow a strobe at which the bus was read low. The block must never drive dominant outside arbitration, and must release the line after losing. Won and lost must never pulse together. The stuff run counter must restart after a stuff bit. The idle count must drop after a dominant sample. Other behaviour can only be shown by the bench. That covers the exact stuffed bit sequence, the position reported on a loss, the decoded field after winning or losing, and starts being ignored across the 10-versus-11 idle boundary. The bench shows these by running the block against a modelled competitor whose bit stream, stuffing and back-off are computed independently.

// File: rtl/canarb_pkg.sv
package canarb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_ARB,
    ST_RECV
  } arb_state_t;
endpackage

// File: rtl/canarb_stuff.sv
// Run-length tracker over sampled bus bits; flags stuff positions.
module canarb_stuff #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic bit_i,
  output logic cur_stuff_o,
  output logic nxt_stuff_o
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] run_q, run_d;
  logic          last_q;

  always_comb begin
    if (run_q == CW'(RUN) || run_q == '0 || bit_i != last_q)
      run_d = CW'(1);
    else
      run_d = run_q + 1'b1;
  end

  assign cur_stuff_o = (run_q == CW'(RUN));
  assign nxt_stuff_o = (run_d == CW'(RUN));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q  <= '0;
      last_q <= 1'b1;
    end else if (adv) begin
      run_q  <= run_d;
      last_q <= bit_i;
    end
  end

  // R3: the bit after a stuff bit can never itself be a stuff position
  a_r3_stuff_restarts: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && cur_stuff_o) |=> !cur_stuff_o);
endmodule

// File: rtl/canarb_idle.sv
// Counts consecutive recessive samples to decide the bus is free.
module canarb_idle #(
  parameter int BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic bit_i,
  output logic idle_o
);
  localparam int CW = $clog2(BITS + 1);

  logic [CW-1:0] cnt_q;

  assign idle_o = (cnt_q == CW'(BITS));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (!bit_i)
        cnt_q <= '0;
      else if (!idle_o)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: a dominant sample always withdraws bus-free status
  a_r7_dominant_clears: assert property (@(posedge clk) disable iff (rst)
    (adv && !bit_i) |=> !idle_o);
endmodule

// File: rtl/canarb_rxsh.sv
// Shift register collecting destuffed field bits from the bus.
module canarb_rxsh #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)
      sh_q <= '0;
    else if (shift)
      sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign data_o = sh_q;
endmodule

// File: rtl/can_arb_tx.sv
module can_arb_tx
  import canarb_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int STUFF_RUN = 5,
  parameter int IDLE_BITS = 11,
  localparam int FW       = ID_W + 1,
  localparam int IW       = $clog2(FW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_tick_i,
  input  logic            rx_i,
  input  logic            start_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            rtr_i,
  output logic            tx_o,
  output logic            won_o,
  output logic            lost_o,
  output logic [IW-1:0]   lost_idx_o,
  output logic            rx_valid_o,
  output logic [ID_W-1:0] rx_id_o,
  output logic            rx_rtr_o
);
  arb_state_t      state_q;
  logic            tx_q, sof_q, won_q, lost_q, rxv_q;
  logic [FW-1:0]   fld_q;
  logic [IW-1:0]   fidx_q, lidx_q;
  logic [FW-1:0]   rx_field;

  logic idle_ok, cur_stuff, nxt_stuff;
  logic in_frame, adv, store, last_bit, lose, begin_sof, nxt_data;

  assign in_frame  = (state_q == ST_ARB) || (state_q == ST_RECV);
  assign adv       = bit_tick_i && in_frame;
  assign begin_sof = bit_tick_i && (state_q == ST_PEND);
  assign store     = adv && !sof_q && !cur_stuff;
  assign last_bit  = store && (fidx_q == IW'(FW - 1));
  assign lose      = adv && (state_q == ST_ARB) && tx_q && !rx_i;
  assign nxt_data  = store ? fld_q[FW-2] : fld_q[FW-1];

  canarb_stuff #(.RUN(STUFF_RUN)) u_stuff (
    .clk(clk), .rst(rst), .clr(begin_sof), .adv(adv), .bit_i(rx_i),
    .cur_stuff_o(cur_stuff), .nxt_stuff_o(nxt_stuff)
  );

  canarb_idle #(.BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst(rst), .clr(last_bit), .adv(bit_tick_i), .bit_i(rx_i),
    .idle_o(idle_ok)
  );

  canarb_rxsh #(.W(FW)) u_rxsh (
    .clk(clk), .rst(rst), .shift(store), .bit_i(rx_i), .data_o(rx_field)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tx_q    <= 1'b1;
      sof_q   <= 1'b0;
      fld_q   <= '0;
      fidx_q  <= '0;
      lidx_q  <= '0;
      won_q   <= 1'b0;
      lost_q  <= 1'b0;
      rxv_q   <= 1'b0;
    end else begin
      won_q  <= 1'b0;
      lost_q <= 1'b0;
      rxv_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i && idle_ok) begin
            fld_q   <= {id_i, rtr_i};
            state_q <= ST_PEND;
          end
        end
        ST_PEND: begin
          if (bit_tick_i) begin
            tx_q    <= 1'b0;
            sof_q   <= 1'b1;
            fidx_q  <= '0;
            state_q <= ST_ARB;
          end
        end
        ST_ARB, ST_RECV: begin
          if (adv) begin
            sof_q <= 1'b0;
            if (store) begin
              fld_q  <= fld_q << 1;
              fidx_q <= fidx_q + 1'b1;
            end
            if (lose) begin
              lost_q  <= 1'b1;
              lidx_q  <= fidx_q;
              tx_q    <= 1'b1;
              state_q <= ST_RECV;
            end
            if (last_bit) begin
              tx_q    <= 1'b1;
              rxv_q   <= 1'b1;
              state_q <= ST_IDLE;
              if (state_q == ST_ARB && !lose)
                won_q <= 1'b1;
            end else if (state_q == ST_ARB && !lose) begin
              tx_q <= nxt_stuff ? ~rx_i : nxt_data;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_o       = tx_q;
  assign won_o      = won_q;
  assign lost_o     = lost_q;
  assign lost_idx_o = lidx_q;
  assign rx_valid_o = rxv_q;
  assign rx_id_o    = rx_field[FW-1:1];
  assign rx_rtr_o   = rx_field[0];

  // R4: a loss is only reported after a strobe that read the bus dominant
  a_r4_loss_cause: assert property (@(posedge clk) disable iff (rst)
    lost_q |-> $past(bit_tick_i && !rx_i));
  // R4: once lost, the line stays released
  a_r4_released: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RECV) |-> tx_q);
  // R4: reported position lies inside the field
  a_r4_idx_range: assert property (@(posedge clk) disable iff (rst)
    lost_q |-> ({1'b0, lidx_q} < (IW + 1)'(FW)));
  // R5: outcomes are exclusive, and a win closes the field
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(won_q && lost_q));
  a_r6_win_has_field: assert property (@(posedge clk) disable iff (rst)
    won_q |-> rxv_q);
  // R2: dominant is driven only while arbitrating
  a_r2_dominant_in_arb: assert property (@(posedge clk) disable iff (rst)
    !tx_q |-> (state_q == ST_ARB));
  // R7: no frame starts before the bus is free
  a_r7_start_needs_idle: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !idle_ok) |=> (state_q == ST_IDLE));
endmodule

// File: tb/can_arb_tx_bench.sv
module can_arb_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0;
  logic        start = 1'b0;
  logic [10:0] id = '0;
  logic        rtr = 1'b0;
  logic        comp_bit = 1'b1;
  logic        bus;
  logic        tx, won, lost, rxv, rx_rtr;
  logic [3:0]  lidx;
  logic [10:0] rx_id;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int t_won = 0, t_lost = 0, t_rxv = 0;
  logic [3:0]  c_idx = '0;
  logic [11:0] c_rx = '0;

  assign bus = tx & comp_bit;

  always #10 clk = ~clk;

  can_arb_tx u_can_arb_tx (
    .clk(clk), .rst(rst), .bit_tick_i(bit_tick), .rx_i(bus),
    .start_i(start), .id_i(id), .rtr_i(rtr),
    .tx_o(tx), .won_o(won), .lost_o(lost), .lost_idx_o(lidx),
    .rx_valid_o(rxv), .rx_id_o(rx_id), .rx_rtr_o(rx_rtr)
  );

  always @(posedge clk) begin
    if (won) t_won <= t_won + 1;
    if (lost) begin
      t_lost <= t_lost + 1;
      c_idx  <= lidx;
    end
    if (rxv) begin
      t_rxv <= t_rxv + 1;
      c_rx  <= {rx_id, rx_rtr};
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic idle_bits(input int n);
    comp_bit = 1'b1;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_start(input logic [11:0] f);
    @(negedge clk);
    start = 1'b1; id = f[11:1]; rtr = f[0];
    @(negedge clk);
    start = 1'b0;
  endtask

  // Stuffed bus stream: start bit, field MSB first, stuff after 5 equal bits.
  function automatic logic [19:0] stuff_stream(input logic [11:0] f, output int len);
    logic [19:0] s;
    int k, run;
    logic last;
    s = '0; s[0] = 1'b0; k = 1; run = 1; last = 1'b0;
    for (int i = 11; i >= 0; i--) begin
      s[k] = f[i]; k++;
      if (f[i] == last) run++;
      else begin run = 1; last = f[i]; end
      if (run == 5 && i > 0) begin
        s[k] = ~last; k++; last = ~last; run = 1;
      end
    end
    len = k;
    return s;
  endfunction

  task automatic run_frame(input logic [11:0] own, input bit cp, input logic [11:0] cf,
                           input bit inject);
    logic [19:0] os, cs, bs;
    int ol, cl, bl, p, q, bad, w0, l0, v0, exp_idx;
    logic [11:0] wf;
    bit exp_win;
    logic etx;
    os = stuff_stream(own, ol);
    cs = stuff_stream(cf, cl);
    exp_win = !(cp && cf < own);
    wf = exp_win ? own : cf;
    bs = stuff_stream(wf, bl);
    p = bl; q = bl;
    for (int k = bl - 1; k >= 0; k--) begin
      if (os[k] != bs[k]) p = k;
      if (cs[k] != bs[k]) q = k;
    end
    exp_idx = 0;
    for (int i = 0; i <= 11; i++)
      if (own[i] != cf[i]) exp_idx = 11 - i;
    w0 = t_won; l0 = t_lost; v0 = t_rxv;
    bad = 0;
    pulse_start(own);
    tick();
    for (int k = 0; k < bl; k++) begin
      comp_bit = (cp && k <= q) ? cs[k] : 1'b1;
      etx = (k <= p) ? os[k] : 1'b1;
      if (tx !== etx) bad++;
      if (inject && k == 3) pulse_start(~own);
      tick();
    end
    comp_bit = 1'b1;
    repeat (2) @(negedge clk);
    check(bad == 0, "R2 R3 R4 bit stream on tx_o", bad, 0);
    check((t_won - w0) == (exp_win ? 1 : 0), "R5 R8 won pulses", t_won - w0, exp_win ? 1 : 0);
    check((t_lost - l0) == (exp_win ? 0 : 1), "R4 R8 lost pulses", t_lost - l0, exp_win ? 0 : 1);
    if (!exp_win)
      check(int'(c_idx) == exp_idx, "R4 losing bit index", int'(c_idx), exp_idx);
    check((t_rxv - v0) == 1, "R6 rx_valid pulses", t_rxv - v0, 1);
    check(c_rx == wf, "R6 R8 received field", int'(c_rx), int'(wf));
  endtask

  initial begin
    void'($urandom(32'h0000_2B5D));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx === 1'b1, "R1 reset tx_o", tx, 1);
    check(won === 1'b0 && lost === 1'b0 && rxv === 1'b0, "R1 reset pulses",
          int'({won, lost, rxv}), 0);

    // R1 R7: only 10 recessive bits after reset, start must be ignored
    idle_bits(10);
    pulse_start(12'h000);
    tick();
    tick();
    check(tx === 1'b1, "R1 R7 start ignored after 10 idle bits", tx, 1);

    run_frame(12'h000, 1'b0, 12'hFFF, 1'b0);   // heavy stuffing, alone
    idle_bits(11);
    run_frame(12'hFFF, 1'b1, 12'h000, 1'b0);   // lose on first bit
    idle_bits(11);
    run_frame(12'h2A5, 1'b1, 12'h2A4, 1'b0);   // lose on request-type bit
    idle_bits(11);
    run_frame(12'h155, 1'b1, 12'h155, 1'b0);   // equal fields, both continue
    idle_bits(11);
    run_frame(12'h010, 1'b1, 12'h020, 1'b1);   // win, with start during frame
    idle_bits(11);
    run_frame(12'h07C, 1'b1, 12'h07B, 1'b1);   // lose with stuffing, start during frame

    // R7: idle count restarts after frame end
    idle_bits(10);
    pulse_start(12'h001);
    tick();
    check(tx === 1'b1, "R7 start ignored 10 bits after frame", tx, 1);

    // R7: dominant sample restarts idle count
    idle_bits(6);
    comp_bit = 1'b0;
    tick();
    comp_bit = 1'b1;
    idle_bits(10);
    pulse_start(12'h001);
    tick();
    check(tx === 1'b1, "R7 start ignored after dominant in idle", tx, 1);

    for (int n = 0; n < 40; n++) begin
      logic [11:0] a, b;
      bit cp;
      a = 12'($urandom());
      b = (n % 5 == 0) ? (a ^ 12'(1 << ($urandom() % 12))) : 12'($urandom());
      cp = ($urandom() % 8) != 0;
      idle_bits(11);
      run_frame(a, cp, b, (n % 7) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad + 1);
      $finish;
    end
  end
endmodule